// File: doc/BRIEF.md
# Signed Bit-Field Extract Unit

This block decodes one instruction word for a signed bit-field extract and executes it on a 32-bit source value. Two encodings are supported, chosen by a select input: a 32-bit conditional form and a compact form built from two halfwords. The unit checks the fixed opcode bits of the chosen form and gathers the field position and width from the immediate pieces of that layout. It then takes `width` adjacent bits of the source starting at `lsb` and copies the field's own top bit into every bit above it.

The datapath is combinational. An optional output register, enabled by default, stores the outputs. The condition check is done elsewhere, and its outcome arrives as `cond_pass_i`. Register file access and hazard handling belong to the surrounding pipeline, which uses `rd_o`, `rn_o`, `we_o` and `result_o`.

Top module: `bfx_unit`

## Requirements
- R1: With `form_sel_i`=1 (compact), the word is valid only if bits [31:20] equal 0xF34, bit 15 is 0 and bit 5 is 0. Otherwise `valid_o`, `we_o` and `unpred_o` are 0 and `result_o` is 0.
- R2: With `form_sel_i`=0 (conditional), the word is valid only if bits [27:21] equal 7'b0111101 and bits [6:4] equal 3'b101. Bits [31:28] are ignored. A mismatch gives the same zeroed outputs as in R1.
- R3: In the compact form, `rn_o`=word[19:16] and `rd_o`=word[11:8]. The field position is {word[14:12], word[7:6]}, and the width minus one is word[4:0].
- R4: In the conditional form, the width minus one is word[20:16], `rd_o`=word[15:12], the field position is word[11:7] and `rn_o`=word[3:0].
- R5: For a valid, in-range word, `result_o` holds bits [lsb+width-1:lsb] of `src_i` in its low `width` bits. Every bit above them equals source bit lsb+width-1.
- R6: Width 32 with lsb 0 returns `src_i` unchanged. Width 1 returns all ones or all zeros, following source bit lsb.
- R7: If lsb+width-1 exceeds 31 on a valid word, then `unpred_o`=1, `we_o`=0 and `result_o`=0.
- R8: In the conditional form, `we_o` is 1 only for a valid, in-range word with `cond_pass_i`=1. The compact form ignores `cond_pass_i`.
- R9: `flags_we_o` is always 0.
- R10: With the output register enabled, outputs follow the inputs one clock later. The asynchronous reset `rst_ni`=0 drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_i | input | 32 | Instruction word; compact form has first halfword in [31:16] |
| form_sel_i | input | 1 | 0 = conditional form, 1 = compact form |
| cond_pass_i | input | 1 | Outcome of the external condition check |
| src_i | input | 32 | Source register value |
| rd_o | output | 4 | Destination register index |
| rn_o | output | 4 | Source register index |
| valid_o | output | 1 | Word matches the selected encoding |
| unpred_o | output | 1 | Field runs past bit 31 |
| we_o | output | 1 | Destination write enable |
| flags_we_o | output | 1 | Condition flag write enable, always 0 |
| result_o | output | 32 | Sign-extended field |

## Verification
Every legal (lsb, width) pair is applied in both forms with random sources, and the result is compared with a bit-by-bit reference. This separates errors in the shift from errors in the mask or in the choice of sign bit. A short vector table covers sources with alternating patterns, all ones and a single bit set. These patterns expose a sign taken from a fixed bit instead of the field top. Directed cases flip single opcode bits in each form, place the field past bit 31, fail the condition in both forms, and use widths 1 and 32. Together they separate the decode, range and write-enable paths from the datapath.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned POS_W  = $clog2(DATA_W);
  localparam int unsigned IDX_W  = 4;

  typedef enum logic {
    FORM_COND    = 1'b0,
    FORM_COMPACT = 1'b1
  } form_e;

  typedef struct packed {
    logic             match;
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] rn;
    logic [POS_W-1:0] lsb;
    logic [POS_W-1:0] wm1;
  } dec_t;

  typedef struct packed {
    logic              valid;
    logic              unpred;
    logic              we;
    logic [IDX_W-1:0]  rd;
    logic [IDX_W-1:0]  rn;
    logic [DATA_W-1:0] result;
  } out_t;
endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
  import bfx_pkg::*;
(
  input  logic [31:0] instr_i,
  input  form_e       form_i,
  output dec_t        dec_o
);
  dec_t cond_d, comp_d;
  logic [3:0] unused_cond;

  assign unused_cond = instr_i[31:28];

  // conditional 32-bit layout
  always_comb begin
    cond_d.match = (instr_i[27:21] == 7'b0111101) && (instr_i[6:4] == 3'b101);
    cond_d.wm1   = instr_i[20:16];
    cond_d.rd    = instr_i[15:12];
    cond_d.lsb   = instr_i[11:7];
    cond_d.rn    = instr_i[3:0];
  end

  // compact layout: first halfword in [31:16]
  always_comb begin
    comp_d.match = (instr_i[31:20] == 12'hF34) && !instr_i[15] && !instr_i[5];
    comp_d.rn    = instr_i[19:16];
    comp_d.rd    = instr_i[11:8];
    comp_d.lsb   = {instr_i[14:12], instr_i[7:6]};
    comp_d.wm1   = instr_i[4:0];
  end

  assign dec_o = (form_i == FORM_COMPACT) ? comp_d : cond_d;
endmodule

// File: rtl/bfx_extract.sv
module bfx_extract #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned POS_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [POS_W-1:0]  lsb_i,
  input  logic [POS_W-1:0]  wm1_i,
  output logic              ovf_o,
  output logic [DATA_W-1:0] field_o
);
  localparam logic [POS_W:0] TOP = POS_W'(DATA_W - 1);

  logic [POS_W:0]    msb;
  logic [DATA_W-1:0] shifted, mask;
  logic              sign;

  assign msb     = {1'b0, lsb_i} + {1'b0, wm1_i};
  assign ovf_o   = msb > TOP;
  assign shifted = src_i >> lsb_i;
  // two-step shift keeps width == DATA_W legal
  assign mask    = ~(({DATA_W{1'b1}} << wm1_i) << 1);
  assign sign    = shifted[wm1_i];
  assign field_o = (shifted & mask) | ({DATA_W{sign}} & ~mask);
endmodule

// File: rtl/bfx_outreg.sv
module bfx_outreg
  import bfx_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  out_t d_i,
  output out_t q_o
);
  if (REG_OUT) begin : g_reg
    out_t q_r;
    logic primed_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_r      <= '0;
        primed_r <= 1'b0;
      end else begin
        q_r      <= d_i;
        primed_r <= 1'b1;
      end
    end
    assign q_o = q_r;

    p_reg_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed_r |-> (q_o == $past(d_i)));
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign q_o = d_i;
  end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       instr_i,
  input  logic              form_sel_i,
  input  logic              cond_pass_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [IDX_W-1:0]  rd_o,
  output logic [IDX_W-1:0]  rn_o,
  output logic              valid_o,
  output logic              unpred_o,
  output logic              we_o,
  output logic              flags_we_o,
  output logic [DATA_W-1:0] result_o
);
  form_e             form;
  dec_t              dec;
  logic              ovf;
  logic [DATA_W-1:0] field;
  out_t              nxt, cur;

  assign form = form_e'(form_sel_i);

  bfx_decode u_dec (
    .instr_i (instr_i),
    .form_i  (form),
    .dec_o   (dec)
  );

  bfx_extract #(.DATA_W(DATA_W)) u_ext (
    .src_i   (src_i),
    .lsb_i   (dec.lsb),
    .wm1_i   (dec.wm1),
    .ovf_o   (ovf),
    .field_o (field)
  );

  always_comb begin
    nxt.valid  = dec.match;
    nxt.unpred = dec.match && ovf;
    nxt.we     = dec.match && !ovf && ((form == FORM_COMPACT) || cond_pass_i);
    nxt.rd     = dec.rd;
    nxt.rn     = dec.rn;
    nxt.result = (dec.match && !ovf) ? field : '0;
  end

  bfx_outreg #(.REG_OUT(REG_OUT)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (nxt),
    .q_o    (cur)
  );

  assign valid_o    = cur.valid;
  assign unpred_o   = cur.unpred;
  assign we_o       = cur.we;
  assign rd_o       = cur.rd;
  assign rn_o       = cur.rn;
  assign result_o   = cur.result;
  assign flags_we_o = 1'b0;

  p_flags_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_we_o);
  p_we_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (valid_o && !unpred_o));
  p_unpred_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unpred_o |-> (result_o == '0 && !we_o));
  p_nomatch_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (result_o == '0 && !unpred_o && !we_o));
endmodule

// File: tb/bfx_unit_test.sv
module bfx_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic        form_sel = 1'b0;
  logic        cond_pass = 1'b0;
  logic [31:0] src = '0;
  logic [3:0]  rd, rn;
  logic        valid, unpred, we, flags_we;
  logic [31:0] result;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  bfx_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .form_sel_i(form_sel),
    .cond_pass_i(cond_pass), .src_i(src), .rd_o(rd), .rn_o(rn),
    .valid_o(valid), .unpred_o(unpred), .we_o(we), .flags_we_o(flags_we),
    .result_o(result)
  );

  // {form, cond_pass, lsb, wm1, src}
  localparam int NV = 8;
  localparam logic [43:0] VEC [NV] = '{
    {1'b0, 1'b1, 5'd4,  5'd7,  32'h0000_0F80},
    {1'b1, 1'b1, 5'd8,  5'd7,  32'h5555_AAAA},
    {1'b0, 1'b1, 5'd0,  5'd31, 32'hDEAD_BEEF},
    {1'b1, 1'b0, 5'd31, 5'd0,  32'h8000_0000},
    {1'b0, 1'b1, 5'd16, 5'd15, 32'h7FFF_0000},
    {1'b1, 1'b1, 5'd3,  5'd0,  32'h0000_0008},
    {1'b0, 1'b1, 5'd12, 5'd3,  32'hFFFF_FFFF},
    {1'b1, 1'b1, 5'd1,  5'd30, 32'hAAAA_AAAA}
  };

  function automatic logic [31:0] ref_field(logic [31:0] s, int l, int w);
    logic [31:0] r;
    for (int i = 0; i < 32; i++)
      r[i] = (i < w) ? s[l+i] : s[l+w-1];
    return r;
  endfunction

  function automatic logic [31:0] enc_cond(logic [3:0] c, logic [4:0] wm1,
      logic [3:0] d, logic [4:0] l, logic [3:0] n);
    return {c, 7'b0111101, wm1, d, l, 3'b101, n};
  endfunction

  function automatic logic [31:0] enc_comp(logic [3:0] n, logic [3:0] d,
      logic [4:0] l, logic [4:0] wm1);
    return {12'hF34, n, 1'b0, l[4:2], d, l[1:0], 1'b0, wm1};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] w, logic f, logic cp, logic [31:0] s);
    instr = w; form_sel = f; cond_pass = cp; src = s;
    @(posedge clk);
    #1;
  endtask

  task automatic run_case(logic f, logic cp, int l, int wm1, logic [31:0] s);
    logic [3:0] d, n;
    logic ovf, exp_we;
    logic [31:0] exp_res;
    d = 4'($urandom);
    n = 4'($urandom);
    ovf = (l + wm1) > 31;
    exp_res = ovf ? 32'h0 : ref_field(s, l, wm1 + 1);
    exp_we = !ovf && (f || cp);
    apply(f ? enc_comp(n, d, 5'(l), 5'(wm1)) : enc_cond(4'($urandom), 5'(wm1), d, 5'(l), n),
          f, cp, s);
    check(f ? "R1" : "R2", {31'b0, valid}, 32'd1);
    check(f ? "R3" : "R4", {24'b0, rd, rn}, {24'b0, d, n});
    check(ovf ? "R7" : "R5", result, exp_res);
    check("R7", {31'b0, unpred}, {31'b0, ovf});
    check("R8", {31'b0, we}, {31'b0, exp_we});
    check("R9", {31'b0, flags_we}, 32'd0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R10 reset state
    src = 32'hFFFF_FFFF;
    instr = enc_comp(4'd3, 4'd5, 5'd0, 5'd31);
    form_sel = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset", {valid, we, unpred, rd, rn} , '0);
    check("R10 reset result", result, 32'h0);
    rst_n = 1'b1;

    // vector table
    for (int i = 0; i < NV; i++)
      run_case(VEC[i][43], VEC[i][42], int'(VEC[i][41:37]), int'(VEC[i][36:32]), VEC[i][31:0]);

    // all legal pairs, both forms, random sources
    for (int l = 0; l < 32; l++)
      for (int wm1 = 0; l + wm1 < 32; wm1++) begin
        run_case(1'b0, 1'b1, l, wm1, $urandom);
        run_case(1'b1, 1'b1, l, wm1, $urandom);
      end

    // R6 boundary widths
    apply(enc_cond(4'hE, 5'd31, 4'd1, 5'd0, 4'd2), 1'b0, 1'b1, 32'h8123_4567);
    check("R6 width32", result, 32'h8123_4567);
    apply(enc_comp(4'd2, 4'd1, 5'd9, 5'd0), 1'b1, 1'b1, 32'h0000_0200);
    check("R6 width1 set", result, 32'hFFFF_FFFF);
    apply(enc_comp(4'd2, 4'd1, 5'd9, 5'd0), 1'b1, 1'b1, 32'hFFFF_FDFF);
    check("R6 width1 clear", result, 32'h0);

    // R7 field beyond bit 31
    apply(enc_cond(4'hE, 5'd15, 4'd1, 5'd20, 4'd2), 1'b0, 1'b1, 32'hFFFF_FFFF);
    check("R7 unpred", {29'b0, unpred, we, valid}, 32'b101);
    check("R7 result", result, 32'h0);
    apply(enc_comp(4'd2, 4'd1, 5'd31, 5'd1), 1'b1, 1'b1, 32'hFFFF_FFFF);
    check("R7 compact unpred", {29'b0, unpred, we, valid}, 32'b101);

    // R8 condition handling
    apply(enc_cond(4'h0, 5'd7, 4'd1, 5'd0, 4'd2), 1'b0, 1'b0, 32'h0000_00FF);
    check("R8 cond fail we", {31'b0, we}, 32'd0);
    apply(enc_comp(4'd2, 4'd1, 5'd0, 5'd7), 1'b1, 1'b0, 32'h0000_00FF);
    check("R8 compact ignores cond", {31'b0, we}, 32'd1);

    // R1 compact opcode mismatches
    for (int b = 0; b < 3; b++) begin
      logic [31:0] w;
      w = enc_comp(4'd2, 4'd1, 5'd0, 5'd7);
      w ^= (b == 0) ? 32'h0010_0000 : (b == 1) ? 32'h0000_8000 : 32'h0000_0020;
      apply(w, 1'b1, 1'b1, 32'hFFFF_FFFF);
      check("R1 mismatch", {29'b0, valid, we, unpred}, 32'd0);
      check("R1 mismatch result", result, 32'h0);
    end
    apply(enc_cond(4'hE, 5'd7, 4'd1, 5'd0, 4'd2), 1'b1, 1'b1, 32'hFF);
    check("R1 wrong form", {31'b0, valid}, 32'd0);

    // R2 conditional opcode mismatches
    for (int b = 0; b < 2; b++) begin
      logic [31:0] w;
      w = enc_cond(4'hE, 5'd7, 4'd1, 5'd0, 4'd2);
      w ^= (b == 0) ? 32'h0020_0000 : 32'h0000_0010;
      apply(w, 1'b0, 1'b1, 32'hFFFF_FFFF);
      check("R2 mismatch", {29'b0, valid, we, unpred}, 32'd0);
      check("R2 mismatch result", result, 32'h0);
    end

    // R10 one-cycle latency and async reset
    instr = enc_comp(4'd2, 4'd1, 5'd4, 5'd3);
    form_sel = 1'b1; cond_pass = 1'b1; src = 32'h0000_0080;
    #1;
    check("R10 not yet", result, 32'h0);
    @(posedge clk);
    #1;
    check("R10 latency", result, 32'hFFFF_FFF8);
    rst_n = 1'b0;
    #1;
    check("R10 async reset", {result[30:0], valid}, 32'h0);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule